// File: doc/BRIEF.md
# Pipelined Narrow-Bus Load/Store Master

This block sits between a processor's load/store stage and a 16-bit pipelined Wishbone bus. The processor hands it one request carrying an address, up to 64 bits of store data, a read/write flag and an access size. The block breaks that request into as many 16-bit bus beats as the size needs. It issues them back to back while the slave is not stalling, and it collects the replies. For a load it reassembles the result into a 64-bit word.

Two one-hot shift registers track the access. The command register decides which beat is presented on the bus and advances each time a beat is accepted. The response register decides which 16-bit lane an incoming reply lands in and advances on each acknowledge. Issue and completion are therefore decoupled. The bus cycle stays open until the response register has drained.

A bus error aborts the access and raises a one-cycle trap toward the processor. A retry reply restarts the whole access from its first beat after a short pseudo-random pause.

Top module: `lsu_narrow_master`

## Requirements
- R1: The size code is 0 for byte, 1 for halfword, 2 for word (32 bits) and 3 for doubleword (64 bits). The access is issued as 1, 1, 2 or 4 strobed beats respectively.
- R2: Beats go out lowest halfword first. Beat k carries the request address with bits [2:1] replaced by (address[2:1] with the low log2(beats) bits cleared) OR k, and bit 0 forced to 0.
- R3: For a store, beat k drives store data bits [16k+15:16k] with byte selects 2'b11. A byte store drives the data byte on both lanes, with select 2'b01 for an even byte address and 2'b10 for an odd one.
- R4: A beat that is strobed while the stall input is high stays on the bus, with the same address, until the first cycle with the stall input low.
- R5: The cycle output rises the cycle after a request is accepted and falls the cycle after the final acknowledge. With no stalls, it is high for N cycles when the slave acknowledges in the strobe cycle and N+1 cycles when it acknowledges one cycle later (N = beat count).
- R6: A load raises the load-valid output for exactly one cycle, in the cycle after the final acknowledge. Beat k's reply sits in bits [16k+15:16k], the bits above the access are zero, and a byte load returns the addressed byte (high half of the reply for an odd address) in bits [7:0]. A store never raises load-valid.
- R7: A single-beat access that the slave acknowledges in its strobe cycle keeps the cycle output high for one cycle only.
- R8: A request presented while the cycle output is high is ignored. No extra beats are issued and no new cycle starts afterwards.
- R9: An error reply during a cycle drops the cycle output and strobe on the next cycle, pulses the trap output for one cycle, and suppresses load-valid.
- R10: A retry reply restarts the access from beat 0 after 1 to 15 cycles with the strobe low. The reissued access then completes with correct load data.
- R11: After reset the cycle, strobe, load-valid and trap outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present (taken only while idle) |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size code |
| req_addr_i | input | 64 | Byte address |
| req_wdata_i | input | 64 | Store data, right-aligned |
| ld_data_o | output | 64 | Load result, zero-extended |
| ld_valid_o | output | 1 | One-cycle load completion strobe |
| trap_o | output | 1 | One-cycle bus fault pulse |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Beat strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | 64 | Beat byte address |
| wb_dat_o | output | 16 | Beat store data |
| wb_sel_o | output | 2 | Byte selects |
| wb_dat_i | input | 16 | Reply data |
| wb_ack_i | input | 1 | Acknowledge |
| wb_stall_i | input | 1 | Slave not accepting beats |
| wb_err_i | input | 1 | Error reply |
| wb_retry_i | input | 1 | Retry reply |

## Verification
Every size is swept over every aligned offset within a doubleword, for both loads and stores, under three slave behaviours. In the first, the slave acknowledges in the strobe cycle; in the second, one cycle later; in the third, it stalls on a pseudo-random pattern. The first two pin down cycle counts and show whether issue and completion really overlap. The stalled runs show whether beats are held rather than skipped or repeated. The per-beat address, select and data checks separate lane-order and slot-alignment faults from assembly faults in the load result. Separate runs inject an error on the second reply, a retry on the second reply, and a second request while busy. These check the abort, restart and ignore paths.

// File: rtl/lsu_nm_pkg.sv
package lsu_nm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } xfer_size_e;

  // Index of the highest beat (beats - 1) for a size code.
  function automatic int unsigned last_beat(input logic [1:0] sz);
    if (sz <= 2'd1) return 0;
    return (1 << (sz - 2'd1)) - 1;
  endfunction

endpackage

// File: rtl/lsu_nm_cmd.sv
module lsu_nm_cmd #(
  parameter int ADDR_W = 64,
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      reload_i,
  input  logic                      advance_i,
  input  logic                      hold_i,
  input  logic [LANES-1:0]          start_oh_i,
  input  logic [$clog2(LANES)-1:0]  last_pos_i,
  input  logic [1:0]                size_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic                      pending_o,
  output logic                      stb_o,
  output logic [ADDR_W-1:0]         adr_o,
  output logic [LANE_W-1:0]         dat_o,
  output logic [LANE_W/8-1:0]       sel_o
);
  localparam int BW    = $clog2(LANES);
  localparam int SEL_W = LANE_W / 8;
  localparam int SELB  = (SEL_W > 1) ? $clog2(SEL_W) : 1;

  logic [LANES-1:0] cmd_q, cmd_d;
  logic             cmd_en;
  logic [BW-1:0]    pos, idx, slot;
  logic             is_byte;

  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = flush_i | reload_i | advance_i;
    if (flush_i)        cmd_d = '0;
    else if (reload_i)  cmd_d = start_oh_i;
    else if (advance_i) cmd_d = cmd_q >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < LANES; i++) begin
      if (cmd_q[i]) pos = BW'(i);
    end
  end

  assign idx       = last_pos_i - pos;
  assign slot      = (base_i[BW:1] & ~last_pos_i) | idx;
  assign is_byte   = (size_i == lsu_nm_pkg::SZ_BYTE);
  assign pending_o = |cmd_q;
  assign stb_o     = pending_o & ~hold_i;
  assign adr_o     = {base_i[ADDR_W-1:BW+1], slot, 1'b0};

  always_comb begin
    if (is_byte) begin
      dat_o = {SEL_W{wdata_i[7:0]}};
      sel_o = SEL_W'(1) << base_i[SELB-1:0];
    end else begin
      dat_o = wdata_i[idx*LANE_W +: LANE_W];
      sel_o = '1;
    end
  end

endmodule

// File: rtl/lsu_nm_rsp.sv
module lsu_nm_rsp #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      reload_i,
  input  logic [LANES-1:0]          start_oh_i,
  input  logic [$clog2(LANES)-1:0]  last_pos_i,
  input  logic [1:0]                size_i,
  input  logic [$clog2(LANE_W/8)-1:0] byte_off_i,
  input  logic                      load_i,
  input  logic                      ack_i,
  input  logic [LANE_W-1:0]         dat_i,
  output logic                      busy_o,
  output logic [LANES*LANE_W-1:0]   ld_data_o,
  output logic                      ld_valid_o
);
  localparam int BW     = $clog2(LANES);
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  rsp_q, rsp_d;
  logic              rsp_en, ack_hit;
  logic [BW-1:0]     pos, idx;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic              valid_d, valid_q;

  assign busy_o  = |rsp_q;
  assign ack_hit = ack_i & busy_o;

  always_comb begin
    rsp_d  = rsp_q;
    rsp_en = flush_i | reload_i | ack_hit;
    if (flush_i)       rsp_d = '0;
    else if (reload_i) rsp_d = start_oh_i;
    else if (ack_hit)  rsp_d = rsp_q >> 1;
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rsp_q[i]) pos = BW'(i);
    end
  end

  assign idx = last_pos_i - pos;

  // The lane under the current response bit follows the bus every
  // cycle; only the value present with the acknowledge survives.
  always_comb begin
    cap_d = cap_q;
    cap_d[idx*LANE_W +: LANE_W] = dat_i;
  end

  assign valid_d = ack_hit & rsp_q[0] & load_i & ~flush_i & ~reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (rsp_en) rsp_q <= rsp_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (busy_o) cap_q <= cap_d;
  end

  always_comb begin
    ld_data_o = '0;
    if (size_i == lsu_nm_pkg::SZ_BYTE) begin
      ld_data_o[7:0] = cap_q[byte_off_i*8 +: 8];
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (BW'(i) <= last_pos_i) ld_data_o[i*LANE_W +: LANE_W] = cap_q[i*LANE_W +: LANE_W];
      end
    end
  end

  assign ld_valid_o = valid_q;

endmodule

// File: rtl/lsu_nm_backoff.sv
module lsu_nm_backoff #(
  parameter bit         ENABLE = 1'b1,
  parameter logic [7:0] SEED   = 8'hA5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic hold_o
);
  generate
    if (ENABLE) begin : g_lfsr
      logic [7:0] lfsr_q, lfsr_d;
      logic [3:0] cnt_q, cnt_d;

      assign lfsr_d = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};

      always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = (lfsr_q[3:0] == 4'd0) ? 4'd1 : lfsr_q[3:0];
        else if (cnt_q != 4'd0) cnt_d = cnt_q - 4'd1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lfsr_q <= SEED;
          cnt_q  <= 4'd0;
        end else begin
          lfsr_q <= lfsr_d;
          cnt_q  <= cnt_d;
        end
      end

      assign hold_o = (cnt_q != 4'd0);
    end else begin : g_none
      assign hold_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/lsu_narrow_master.sv
module lsu_narrow_master #(
  parameter int         ADDR_W     = 64,
  parameter int         LANE_W     = 16,
  parameter int         LANES      = 4,
  parameter bit         BACKOFF_EN = 1'b1,
  parameter logic [7:0] LFSR_SEED  = 8'hA5,
  localparam int        DATA_W     = LANES * LANE_W,
  localparam int        SEL_W      = LANE_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_valid_o,
  output logic              trap_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [LANE_W-1:0] wb_dat_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  input  logic [LANE_W-1:0] wb_dat_i,
  input  logic              wb_ack_i,
  input  logic              wb_stall_i,
  input  logic              wb_err_i,
  input  logic              wb_retry_i
);
  localparam int BW   = $clog2(LANES);
  localparam int SELB = (SEL_W > 1) ? $clog2(SEL_W) : 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // request hold registers
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        size_q;
  logic              we_q;

  logic              busy, accept, err_hit, retry_hit, reload, advance;
  logic              hold, cmd_pending, trap_q;
  logic [1:0]        start_size;
  logic [BW-1:0]     start_pos, run_pos;
  logic [LANES-1:0]  start_oh;

  assign accept     = req_valid_i & ~busy;
  assign err_hit    = wb_err_i & busy;
  assign retry_hit  = wb_retry_i & busy & ~err_hit;
  assign reload     = accept | retry_hit;
  assign start_size = accept ? req_size_i : size_q;
  assign start_pos  = BW'(lsu_nm_pkg::last_beat(start_size));
  assign start_oh   = LANES'(1) << start_pos;
  assign run_pos    = BW'(lsu_nm_pkg::last_beat(size_q));
  assign advance    = busy & cmd_pending & ~wb_stall_i & ~hold;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      wdata_q <= '0;
      size_q  <= 2'd0;
      we_q    <= 1'b0;
    end else if (accept) begin
      base_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      size_q  <= req_size_i;
      we_q    <= req_we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= err_hit;
  end

  lsu_nm_cmd #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .flush_i    (err_hit),
    .reload_i   (reload),
    .advance_i  (advance),
    .hold_i     (hold),
    .start_oh_i (start_oh),
    .last_pos_i (run_pos),
    .size_i     (size_q),
    .base_i     (base_q),
    .wdata_i    (wdata_q),
    .pending_o  (cmd_pending),
    .stb_o      (wb_stb_o),
    .adr_o      (wb_adr_o),
    .dat_o      (wb_dat_o),
    .sel_o      (wb_sel_o)
  );

  lsu_nm_rsp #(.LANE_W(LANE_W), .LANES(LANES)) u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .flush_i    (err_hit),
    .reload_i   (reload),
    .start_oh_i (start_oh),
    .last_pos_i (run_pos),
    .size_i     (size_q),
    .byte_off_i (base_q[SELB-1:0]),
    .load_i     (~we_q),
    .ack_i      (wb_ack_i),
    .dat_i      (wb_dat_i),
    .busy_o     (busy),
    .ld_data_o  (ld_data_o),
    .ld_valid_o (ld_valid_o)
  );

  lsu_nm_backoff #(.ENABLE(BACKOFF_EN), .SEED(LFSR_SEED)) u_backoff (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (retry_hit),
    .hold_o  (hold)
  );

  assign wb_cyc_o = busy;
  assign wb_we_o  = we_q;
  assign trap_o   = trap_q;

endmodule

// File: rtl/lsu_nm_chk.sv
module lsu_nm_chk #(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic [SEL_W-1:0]  wb_sel_o,
  input logic              wb_stall_i,
  input logic              wb_err_i,
  input logic              wb_retry_i,
  input logic              ld_valid_o,
  input logic              trap_o
);

  p_adr_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> !wb_adr_o[0]);

  p_sel_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> (wb_sel_o != '0));

  p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_stb_o && wb_stall_i && !wb_err_i && !wb_retry_i)
      |=> (wb_stb_o && $stable(wb_adr_o)));

  p_stb_in_cyc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o);

  p_valid_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> !wb_cyc_o);

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |=> !ld_valid_o);

  p_err_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_err_i) |=> (!wb_cyc_o && !wb_stb_o && trap_o && !ld_valid_o));

  p_trap_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !trap_o);

endmodule

bind lsu_narrow_master lsu_nm_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wb_cyc_o   (wb_cyc_o),
  .wb_stb_o   (wb_stb_o),
  .wb_adr_o   (wb_adr_o),
  .wb_sel_o   (wb_sel_o),
  .wb_stall_i (wb_stall_i),
  .wb_err_i   (wb_err_i),
  .wb_retry_i (wb_retry_i),
  .ld_valid_o (ld_valid_o),
  .trap_o     (trap_o)
);

// File: tb/lsu_narrow_master_tb.sv
`timescale 1ns/1ps
module lsu_narrow_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [63:0] req_addr = '0, req_wdata = '0;
  logic [63:0] ld_data;
  logic        ld_valid, trap, cyc, stb, we;
  logic [63:0] adr;
  logic [15:0] dat_o, dat_i;
  logic [1:0]  sel;
  logic        ack, stall = 1'b0, err, retry;

  int  n_tests = 0, n_fail = 0;
  bit  lat0 = 1'b1;
  int  stall_mode = 0;
  bit  err_arm = 1'b0, retry_arm = 1'b0;
  int  resp_cnt = 0;
  logic        ack_q = 1'b0;
  logic [15:0] dat_q = '0;
  logic [7:0]  tb_lfsr = 8'h3C;

  always #2.5 clk = ~clk;

  lsu_narrow_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ld_data_o(ld_data), .ld_valid_o(ld_valid), .trap_o(trap),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_adr_o(adr),
    .wb_dat_o(dat_o), .wb_sel_o(sel), .wb_dat_i(dat_i), .wb_ack_i(ack),
    .wb_stall_i(stall), .wb_err_i(err), .wb_retry_i(retry));

  function automatic logic [15:0] rd(input logic [63:0] a);
    return {a[7:0] + 8'h11, a[15:8] ^ a[7:0] ^ 8'hC3};
  endfunction

  // slave model
  logic acc, resp_now;
  assign acc      = cyc & stb & ~stall;
  assign resp_now = lat0 ? acc : ack_q;
  assign err      = resp_now & err_arm & (resp_cnt == 1);
  assign retry    = resp_now & retry_arm & (resp_cnt == 1) & ~err;
  assign ack      = resp_now & ~err & ~retry;
  assign dat_i    = lat0 ? rd(adr) : dat_q;

  always @(posedge clk) begin
    ack_q   <= acc;
    dat_q   <= rd(adr);
    tb_lfsr <= {tb_lfsr[6:0], tb_lfsr[7] ^ tb_lfsr[5] ^ tb_lfsr[4] ^ tb_lfsr[3]};
    case (stall_mode)
      1:       stall <= ~stall;
      2:       stall <= tb_lfsr[0] & tb_lfsr[2];
      default: stall <= 1'b0;
    endcase
    if (req_valid && !cyc)   resp_cnt <= 0;
    else if (resp_now && cyc) resp_cnt <= resp_cnt + 1;
  end

  // observer, sampled on the falling edge
  logic [63:0] log_adr [0:7];
  logic [15:0] log_dat [0:7];
  logic [1:0]  log_sel [0:7];
  int          log_n, ld_cnt, trap_cnt, cyc_cnt, gap_cnt, hold_bad;
  logic [63:0] ld_seen, prev_adr;
  bit          prev_held;

  always @(negedge clk) begin
    if (req_valid && !cyc) begin
      log_n = 0; ld_cnt = 0; trap_cnt = 0; cyc_cnt = 0; gap_cnt = 0;
      hold_bad = 0; prev_held = 1'b0;
    end else begin
      if (prev_held && !(stb && adr == prev_adr)) hold_bad++;
      prev_held = cyc && stb && stall && !err && !retry;
      prev_adr  = adr;
      if (acc && log_n < 8) begin
        log_adr[log_n] = adr; log_dat[log_n] = dat_o; log_sel[log_n] = sel;
        log_n++;
      end
      if (cyc) cyc_cnt++;
      if (cyc && !stb) gap_cnt++;
      if (ld_valid) begin ld_cnt++; ld_seen = ld_data; end
      if (trap) trap_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int beats(input logic [1:0] sz);
    return (sz <= 2'd1) ? 1 : (sz == 2'd2 ? 2 : 4);
  endfunction

  function automatic logic [63:0] beat_adr(input logic [63:0] a, input logic [1:0] sz, input int k);
    logic [1:0] slot;
    slot = (a[2:1] & ~2'(beats(sz) - 1)) | 2'(k);
    return {a[63:3], slot, 1'b0};
  endfunction

  function automatic logic [63:0] exp_load(input logic [63:0] a, input logic [1:0] sz);
    logic [63:0] r;
    logic [15:0] h;
    r = '0;
    if (sz == 2'd0) begin
      h = rd({a[63:1], 1'b0});
      r[7:0] = a[0] ? h[15:8] : h[7:0];
    end else begin
      for (int k = 0; k < beats(sz); k++) r[16*k +: 16] = rd(beat_adr(a, sz, k));
    end
    return r;
  endfunction

  task automatic issue(input logic w, input logic [1:0] sz, input logic [63:0] a,
                       input logic [63:0] wd, input bit poke);
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = w; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (poke) begin
      @(posedge clk); #1;
      req_valid = 1'b1; req_addr = a ^ 64'h100; req_we = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
    for (int t = 0; t < 400 && cyc; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep_one(input logic w, input logic [1:0] sz, input logic [63:0] a);
    logic [63:0] wd;
    int nb;
    nb = beats(sz);
    wd = 64'h0123_4567_89AB_CDEF ^ {a[7:0], a[7:0], 48'h5A5A_0F0F_3C3C};
    issue(w, sz, a, wd, 1'b0);
    chk(log_n == nb, "R1", "beat count", 64'(log_n), 64'(nb));
    for (int k = 0; k < nb && k < log_n; k++) begin
      chk(log_adr[k] == beat_adr(a, sz, k), "R2", "beat address", log_adr[k], beat_adr(a, sz, k));
      if (w) begin
        if (sz == 2'd0) begin
          chk(log_dat[k] == {2{wd[7:0]}}, "R3", "byte store data", 64'(log_dat[k]), 64'({2{wd[7:0]}}));
          chk(log_sel[k] == (a[0] ? 2'b10 : 2'b01), "R3", "byte select", 64'(log_sel[k]), a[0] ? 64'd2 : 64'd1);
        end else begin
          chk(log_dat[k] == wd[16*k +: 16], "R3", "store beat data", 64'(log_dat[k]), 64'(wd[16*k +: 16]));
          chk(log_sel[k] == 2'b11, "R3", "halfword select", 64'(log_sel[k]), 64'd3);
        end
      end
    end
    chk(hold_bad == 0, "R4", "stalled beat moved", 64'(hold_bad), 64'd0);
    if (w) chk(ld_cnt == 0, "R6", "load-valid on store", 64'(ld_cnt), 64'd0);
    else begin
      chk(ld_cnt == 1, "R6", "load-valid pulses", 64'(ld_cnt), 64'd1);
      chk(ld_seen == exp_load(a, sz), "R6", "load data", ld_seen, exp_load(a, sz));
    end
    if (stall_mode == 0) begin
      chk(cyc_cnt == nb + (lat0 ? 0 : 1), "R5", "cycle length", 64'(cyc_cnt), 64'(nb + (lat0 ? 0 : 1)));
      if (lat0 && nb == 1) chk(cyc_cnt == 1, "R7", "single-cycle access", 64'(cyc_cnt), 64'd1);
    end
    chk(trap_cnt == 0, "R9", "spurious trap", 64'(trap_cnt), 64'd0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cyc && !stb && !ld_valid && !trap, "R11", "idle after reset",
        {60'd0, cyc, stb, ld_valid, trap}, 64'd0);

    for (int m = 0; m < 3; m++) begin
      for (int l = 0; l < 2; l++) begin
        stall_mode = m; lat0 = (l == 0);
        for (int w = 0; w < 2; w++) begin
          for (int s = 0; s < 4; s++) begin
            for (int off = 0; off < 8; off++) begin
              if ((off % (1 << s)) == 0)
                sweep_one(w[0], 2'(s), 64'h1000_0000_0000_0040 + 64'(off));
            end
          end
        end
      end
    end

    // request while busy is ignored
    stall_mode = 1; lat0 = 1'b0;
    issue(1'b0, 2'd3, 64'h2000_0000_0000_0080, '0, 1'b1);
    chk(log_n == 4, "R8", "beats with request while busy", 64'(log_n), 64'd4);
    repeat (3) @(negedge clk);
    chk(!cyc, "R8", "no cycle after ignored request", 64'(cyc), 64'd0);
    chk(ld_seen == exp_load(64'h2000_0000_0000_0080, 2'd3), "R8", "data intact",
        ld_seen, exp_load(64'h2000_0000_0000_0080, 2'd3));

    // error on the second reply
    stall_mode = 0; lat0 = 1'b1; err_arm = 1'b1;
    issue(1'b0, 2'd3, 64'h3000_0000_0000_0008, '0, 1'b0);
    err_arm = 1'b0;
    chk(trap_cnt == 1, "R9", "trap pulses", 64'(trap_cnt), 64'd1);
    chk(cyc_cnt == 2, "R9", "cycle ends after error", 64'(cyc_cnt), 64'd2);
    chk(ld_cnt == 0, "R9", "no load-valid after error", 64'(ld_cnt), 64'd0);
    sweep_one(1'b0, 2'd2, 64'h3000_0000_0000_0014);

    // retry on the second reply
    retry_arm = 1'b1;
    issue(1'b0, 2'd3, 64'h4000_0000_0000_0010, '0, 1'b0);
    retry_arm = 1'b0;
    chk(log_n == 6, "R10", "beats incl. reissue", 64'(log_n), 64'd6);
    for (int k = 0; k < 4; k++)
      chk(log_adr[k + 2] == beat_adr(64'h4000_0000_0000_0010, 2'd3, k), "R10", "reissue order",
          log_adr[k + 2], beat_adr(64'h4000_0000_0000_0010, 2'd3, k));
    chk(gap_cnt >= 1 && gap_cnt <= 15, "R10", "back-off length", 64'(gap_cnt), 64'd15);
    chk(cyc_cnt == 6 + gap_cnt, "R10", "cycle length with back-off", 64'(cyc_cnt), 64'(6 + gap_cnt));
    chk(ld_cnt == 1 && ld_seen == exp_load(64'h4000_0000_0000_0010, 2'd3), "R10", "load after retry",
        ld_seen, exp_load(64'h4000_0000_0000_0010, 2'd3));
    chk(trap_cnt == 0, "R10", "no trap on retry", 64'(trap_cnt), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule